// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Hourly Chime

This block keeps the time of day as six BCD digits: two for hours, two for minutes and two for seconds. It moves forward only in cycles where a single-cycle once-per-second enable is high. Seconds and minutes wrap after 59 and hours wrap after 23, so the largest value shown is 23:59:59. Downstream logic can wire the digits straight to display decoders. The block does not generate the one-second enable itself, and it does not drive the displays or a sounder.

An operator sets the clock with two separate correction inputs. One steps the hours and the other steps the minutes. Each correction stays inside its own field. Any correction also clears the seconds, so the clock restarts cleanly on the minute. An hourly chime is raised for the first ten seconds of every hour that the clock reaches by counting. A one-cycle day-carry pulse marks the change from 23:59:59 to midnight, and a calendar can use it.

Every cycle is classified into one of three actions: ACT_IDLE (no input), ACT_COUNT (the tick is accepted) or ACT_SET (at least one correction input is high, and any tick in that cycle is dropped). The chime is a two-state machine with states CHM_QUIET and CHM_RING. Its transitions are:
- HOUR_TOP (CHM_QUIET to CHM_RING): an accepted tick carries from 59:59 into a new hour.
- WINDOW_END (CHM_RING to CHM_QUIET): an accepted tick moves the seconds from 09 to 10.
- SILENCED (CHM_RING to CHM_QUIET): any correction cycle.

Top module: `tod_bcd_clock`

## Requirements
- R1: Each digit output is a 4-bit BCD value (0 to 9, tens in the same 4-bit code). The time changes only in cycles where `tick`, `adj_hour` or `adj_min` is high. In all other cycles every digit holds.
- R2: The seconds count 00 to 59. An accepted tick at 59 gives 00 and advances the minutes by exactly one.
- R3: The minutes count 00 to 59. A counted carry out of 59 gives 00 and advances the hours by exactly one.
- R4: The hours count 00 to 23. A counted advance from 23, which would form tens 2 and units 4, clears both hour digits to 00.
- R5: Each cycle with `adj_hour` high adds one to the hours, wrapping from 23 to 00. The minutes are unchanged and `day_carry` stays low.
- R6: Each cycle with `adj_min` high adds one to the minutes, wrapping from 59 to 00. The hours are unchanged, including on that wrap.
- R7: In any correction cycle the seconds become 00 and a coincident `tick` is discarded. When both correction inputs are high together, both fields step.
- R8: When the time reaches hh:00:00 by counting, `chime` is high from the cycle that shows hh:00:00 through hh:00:09. It falls in the cycle that shows hh:00:10.
- R9: A correction cycle forces `chime` low. A correction that lands on minute 00 does not raise it.
- R10: `day_carry` is high for exactly one cycle, the cycle whose outputs first show 00:00:00 after 23:59:59 advanced by a tick. It is low at all other times.
- R11: A synchronous `rst` has priority over all other inputs. The cycle after it shows 00:00:00 with `chime` and `day_carry` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle once-per-second advance enable |
| adj_hour | input | 1 | Hour correction, one step per cycle high |
| adj_min | input | 1 | Minute correction, one step per cycle high |
| hour_tens | output | 4 | Hours tens digit, BCD |
| hour_units | output | 4 | Hours units digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD |
| min_units | output | 4 | Minutes units digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD |
| sec_units | output | 4 | Seconds units digit, BCD |
| chime | output | 1 | High during the first ten seconds of a counted hour |
| day_carry | output | 1 | One-cycle pulse on the change to midnight |

## Verification
Two collisions can occur in a single cycle:
- A tick and a correction pulse arriving together. This must give exactly one correction step, seconds 00 and no counted second.
- A correction arriving while the chime is ringing. This must end the chime at once rather than at second 10.

The bench provokes both on purpose. It drives `tick` together with one or both correction inputs, and it applies hour and minute corrections inside a chime window and again at the 59-to-00 minute wrap. An arithmetic seconds-of-day model judges each result, after a full 86400-tick sweep has already checked every digit, chime edge and the midnight carry.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int BCD_W = 4;

    typedef logic [BCD_W-1:0] bcd_t;

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_COUNT = 2'd1,
        ACT_SET   = 2'd2
    } act_e;

    typedef enum logic {
        CHM_QUIET = 1'b0,
        CHM_RING  = 1'b1
    } chime_e;

    function automatic int bcd_pair_value(input bcd_t tens, input bcd_t units);
        return int'(tens) * 10 + int'(units);
    endfunction

endpackage

// File: rtl/tod_bcd_field.sv
module tod_bcd_field
    import tod_pkg::*;
#(
    parameter int MODULUS = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output bcd_t tens,
    output bcd_t units,
    output logic at_top
);

    localparam int TOP_T = (MODULUS - 1) / 10;
    localparam int TOP_U = (MODULUS - 1) % 10;
    localparam int HIT_T = MODULUS / 10;
    localparam int HIT_U = MODULUS % 10;

    bcd_t nx_t;
    bcd_t nx_u;

    // Raw BCD increment, then clear on the pattern one past the top value.
    always_comb begin
        if (units == bcd_t'(9)) begin
            nx_u = '0;
            nx_t = tens + bcd_t'(1);
        end else begin
            nx_u = units + bcd_t'(1);
            nx_t = tens;
        end
        if (nx_t == bcd_t'(HIT_T) && nx_u == bcd_t'(HIT_U)) begin
            nx_t = '0;
            nx_u = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tens  <= '0;
            units <= '0;
        end else if (inc) begin
            tens  <= nx_t;
            units <= nx_u;
        end
    end

    assign at_top = (tens == bcd_t'(TOP_T)) && (units == bcd_t'(TOP_U));

endmodule

// File: rtl/tod_chime_fsm.sv
module tod_chime_fsm
    import tod_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  act_e act,
    input  logic hour_top,
    input  logic win_end,
    output logic chime
);

    chime_e state;
    chime_e state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CHM_QUIET;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CHM_QUIET: begin
                // HOUR_TOP
                if (act == ACT_COUNT && hour_top) begin
                    state_nx = CHM_RING;
                end
            end
            CHM_RING: begin
                // SILENCED or WINDOW_END
                if (act == ACT_SET) begin
                    state_nx = CHM_QUIET;
                end else if (act == ACT_COUNT && win_end) begin
                    state_nx = CHM_QUIET;
                end
            end
            default: state_nx = CHM_QUIET;
        endcase
    end

    always_comb begin
        chime = (state == CHM_RING);
    end

endmodule

// File: rtl/tod_bcd_clock.sv
module tod_bcd_clock
    import tod_pkg::*;
#(
    parameter int SEC_MOD    = 60,
    parameter int MIN_MOD    = 60,
    parameter int HR_MOD     = 24,
    parameter int CHIME_SECS = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       adj_hour,
    input  logic       adj_min,
    output logic [3:0] hour_tens,
    output logic [3:0] hour_units,
    output logic [3:0] min_tens,
    output logic [3:0] min_units,
    output logic [3:0] sec_tens,
    output logic [3:0] sec_units,
    output logic       chime,
    output logic       day_carry
);

    localparam int WIN_LAST = CHIME_SECS - 1;

    act_e act;
    logic sec_top;
    logic min_top;
    logic hr_top;
    logic sec_inc;
    logic sec_clr;
    logic min_inc;
    logic hr_inc;
    logic win_end;
    logic day_carry_q;

    // Action decode: correction beats the tick.
    always_comb begin
        if (adj_hour || adj_min) begin
            act = ACT_SET;
        end else if (tick) begin
            act = ACT_COUNT;
        end else begin
            act = ACT_IDLE;
        end
    end

    assign sec_inc = (act == ACT_COUNT);
    assign sec_clr = (act == ACT_SET);
    assign min_inc = (sec_inc && sec_top) || adj_min;
    assign hr_inc  = (sec_inc && sec_top && min_top) || adj_hour;
    assign win_end = (bcd_pair_value(sec_tens, sec_units) == WIN_LAST);

    tod_bcd_field #(.MODULUS(SEC_MOD)) u_sec (
        .clk    (clk),
        .rst    (rst),
        .clr    (sec_clr),
        .inc    (sec_inc),
        .tens   (sec_tens),
        .units  (sec_units),
        .at_top (sec_top)
    );

    tod_bcd_field #(.MODULUS(MIN_MOD)) u_min (
        .clk    (clk),
        .rst    (rst),
        .clr    (1'b0),
        .inc    (min_inc),
        .tens   (min_tens),
        .units  (min_units),
        .at_top (min_top)
    );

    tod_bcd_field #(.MODULUS(HR_MOD)) u_hr (
        .clk    (clk),
        .rst    (rst),
        .clr    (1'b0),
        .inc    (hr_inc),
        .tens   (hour_tens),
        .units  (hour_units),
        .at_top (hr_top)
    );

    tod_chime_fsm u_chime (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .hour_top (sec_top && min_top),
        .win_end  (win_end),
        .chime    (chime)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            day_carry_q <= 1'b0;
        end else begin
            day_carry_q <= sec_inc && sec_top && min_top && hr_top;
        end
    end

    assign day_carry = day_carry_q;

endmodule

// File: rtl/tod_bcd_clock_chk.sv
module tod_bcd_clock_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       adj_hour,
    input logic       adj_min,
    input logic [3:0] hour_tens,
    input logic [3:0] hour_units,
    input logic [3:0] min_tens,
    input logic [3:0] min_units,
    input logic [3:0] sec_tens,
    input logic [3:0] sec_units,
    input logic       chime,
    input logic       day_carry
);

    logic [23:0] tod;
    int          hr_val;
    assign tod    = {hour_tens, hour_units, min_tens, min_units, sec_tens, sec_units};
    assign hr_val = int'(hour_tens) * 10 + int'(hour_units);

    // R1
    bcd_digits_chk: assert property (@(posedge clk) disable iff (rst)
        (hour_units <= 4'd9) && (min_units <= 4'd9) && (sec_units <= 4'd9)
        && (min_tens <= 4'd5) && (sec_tens <= 4'd5));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !adj_hour && !adj_min) |=> $stable(tod));

    // R4
    hour_range_chk: assert property (@(posedge clk) disable iff (rst)
        hr_val <= 23);

    // R5
    hour_step_chk: assert property (@(posedge clk) disable iff (rst)
        adj_hour |=> hr_val == ($past(hr_val) + 1) % 24);

    // R6
    min_keeps_hour_chk: assert property (@(posedge clk) disable iff (rst)
        (adj_min && !adj_hour) |=> $stable({hour_tens, hour_units}));

    // R7
    set_clears_sec_chk: assert property (@(posedge clk) disable iff (rst)
        (adj_hour || adj_min) |=> (sec_tens == 4'd0 && sec_units == 4'd0));

    // R8
    chime_window_chk: assert property (@(posedge clk) disable iff (rst)
        chime |-> (min_tens == 4'd0 && min_units == 4'd0 && sec_tens == 4'd0));

    // R9
    set_silences_chk: assert property (@(posedge clk) disable iff (rst)
        (adj_hour || adj_min) |=> !chime);

    // R10
    carry_midnight_chk: assert property (@(posedge clk) disable iff (rst)
        day_carry |-> (tod == 24'h0));

    // R10
    carry_single_chk: assert property (@(posedge clk) disable iff (rst)
        day_carry |=> !day_carry);

    // R11
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (tod == 24'h0 && !chime && !day_carry));

endmodule

bind tod_bcd_clock tod_bcd_clock_chk u_tod_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .adj_hour   (adj_hour),
    .adj_min    (adj_min),
    .hour_tens  (hour_tens),
    .hour_units (hour_units),
    .min_tens   (min_tens),
    .min_units  (min_units),
    .sec_tens   (sec_tens),
    .sec_units  (sec_units),
    .chime      (chime),
    .day_carry  (day_carry)
);

// File: tb/test_tod_bcd_clock.sv
`timescale 1ns/1ps
module test_tod_bcd_clock;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       adj_hour = 1'b0;
    logic       adj_min = 1'b0;
    logic [3:0] hour_tens, hour_units, min_tens, min_units, sec_tens, sec_units;
    logic       chime, day_carry;

    int compared = 0;
    int mismatched = 0;
    int t_m = 0;
    bit chime_m = 1'b0;
    bit dc_m = 1'b0;

    always #4 clk = ~clk;

    tod_bcd_clock i_tod_bcd_clock (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .adj_hour   (adj_hour),
        .adj_min    (adj_min),
        .hour_tens  (hour_tens),
        .hour_units (hour_units),
        .min_tens   (min_tens),
        .min_units  (min_units),
        .sec_tens   (sec_tens),
        .sec_units  (sec_units),
        .chime      (chime),
        .day_carry  (day_carry)
    );

    function automatic logic [23:0] tod_of(input int t);
        int h, m, s;
        h = t / 3600;
        m = (t / 60) % 60;
        s = t % 60;
        return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
    endfunction

    task automatic compare(input string req);
        logic [23:0] act_v;
        logic [23:0] exp_v;
        act_v = {hour_tens, hour_units, min_tens, min_units, sec_tens, sec_units};
        exp_v = tod_of(t_m);
        compared++;
        if (act_v !== exp_v || chime !== chime_m || day_carry !== dc_m) begin
            mismatched++;
            $display("FAIL %s: time=%h chime=%b carry=%b expected time=%h chime=%b carry=%b",
                     req, act_v, chime, day_carry, exp_v, chime_m, dc_m);
        end
    endtask

    task automatic model_step(input bit t, input bit ah, input bit am);
        int h, m;
        dc_m = 1'b0;
        if (ah || am) begin
            h = t_m / 3600;
            m = (t_m / 60) % 60;
            if (ah) h = (h + 1) % 24;
            if (am) m = (m + 1) % 60;
            t_m = h * 3600 + m * 60;
            chime_m = 1'b0;
        end else if (t) begin
            dc_m = (t_m == 86399);
            t_m = (t_m + 1) % 86400;
            if (t_m % 3600 == 0) chime_m = 1'b1;
            else if (t_m % 3600 == 10) chime_m = 1'b0;
        end
    endtask

    task automatic cyc(input bit t, input bit ah, input bit am, input string req);
        tick = t;
        adj_hour = ah;
        adj_min = am;
        @(posedge clk);
        @(negedge clk);
        model_step(t, ah, am);
        compare(req);
    endtask

    task automatic do_reset(input bit t);
        rst = 1'b1;
        tick = t;
        adj_hour = t;
        adj_min = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_m = 0;
        chime_m = 1'b0;
        dc_m = 1'b0;
        compare("R11");
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        mismatched++;
        $display("FAIL R1 watchdog: run did not finish, actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(1'b0);
        // R1: no input, nothing moves
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 1'b0, "R1");
        // Full day sweep: R2 R3 R4 R8 R10
        for (int i = 0; i < 86401; i++) cyc(1'b1, 1'b0, 1'b0, "R2/R3/R4/R8/R10");
        // Sparse ticks with idle gaps: R1
        for (int i = 0; i < 150; i++) begin
            cyc(1'b1, 1'b0, 1'b0, "R1");
            cyc(1'b0, 1'b0, 1'b0, "R1");
        end
        // Hour correction over a full wrap: R5
        for (int i = 0; i < 25; i++) cyc(1'b0, 1'b1, 1'b0, "R5");
        // Minute correction over a full wrap, hours held: R6
        for (int i = 0; i < 61; i++) cyc(1'b0, 1'b0, 1'b1, "R6");
        // Collisions: tick with a correction, both corrections together: R7
        for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0, 1'b0, "R7");
        cyc(1'b1, 1'b1, 1'b0, "R7");
        for (int i = 0; i < 7; i++) cyc(1'b1, 1'b0, 1'b0, "R7");
        cyc(1'b1, 1'b0, 1'b1, "R7");
        cyc(1'b0, 1'b1, 1'b1, "R7");
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b1, "R7");
        // Hour at 23 and minutes at 59: count to midnight again, with corrections first
        while ((t_m / 60) % 60 != 59) cyc(1'b0, 1'b0, 1'b1, "R6");
        while (t_m / 3600 != 23) cyc(1'b0, 1'b1, 1'b0, "R5");
        for (int i = 0; i < 65; i++) cyc(1'b1, 1'b0, 1'b0, "R10/R8");
        // Correction in the chime window: R9
        while ((t_m / 60) % 60 != 59) cyc(1'b0, 1'b0, 1'b1, "R9");
        for (int i = 0; i < 63; i++) cyc(1'b1, 1'b0, 1'b0, "R8");
        cyc(1'b1, 1'b1, 1'b0, "R9");
        for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0, 1'b0, "R9");
        while ((t_m / 60) % 60 != 59) cyc(1'b0, 1'b0, 1'b1, "R9");
        for (int i = 0; i < 62; i++) cyc(1'b1, 1'b0, 1'b0, "R8");
        cyc(1'b1, 1'b0, 1'b1, "R9");
        for (int i = 0; i < 58; i++) cyc(1'b0, 1'b0, 1'b1, "R9");
        cyc(1'b1, 1'b0, 1'b1, "R9");
        for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0, 1'b0, "R9");
        // Reset beats concurrent inputs: R11
        do_reset(1'b1);
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b0, "R11");
        tick = 1'b0;
        adj_hour = 1'b0;
        adj_min = 1'b0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule